// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between a UART bit deserialiser and the software-facing side of a serial port. The deserialiser hands over each finished character, with its parity-error and framing-error flags, as a one-cycle strobe when it detects the stop bit. The character first lands in a single holding stage. From there it moves into a four-entry first-in first-out queue as soon as the queue has room. The holding stage and the queue together can keep five characters before anything is lost.

Software sees a data-available flag and the oldest queued character with its two error flags. A one-cycle read strobe retires that character and brings up the next one. Reading an empty queue changes nothing, and the outputs keep the last character that was read. A receive interrupt pulse fires on transfers from the holding stage into the queue. A 2-bit mode input selects when it fires: on every transfer, when the queue reaches three entries, or when it becomes full. A sticky overrun flag records a character that arrived when there was nowhere to put it. It stays set until software pulses a clear input.

Top module: `uart_rx_buffer`

## Requirements
- R1: Five characters delivered with no reads in between are all kept: four in the queue and one in the holding stage. The overrun flag stays 0 and the queue occupancy never goes above four.
- R2: `rx_avail` is 1 exactly when the queue holds at least one character. A character strobed in at clock edge k into an empty block makes `rx_avail` 1 after edge k+1.
- R3: `rx_data`, `rx_perr` and `rx_ferr` show the oldest queued character and its flags. Each read retires it, and the next character and its own flags appear after that clock edge, in arrival order.
- R4: A read strobe while `rx_avail` is 0 leaves the queue empty. The outputs keep the value of the last character read, or 0 if none has been read since reset.
- R5: With `irq_sel` = 2'b00 or 2'b01, `rx_irq` pulses for one cycle after every transfer from the holding stage into the queue.
- R6: With `irq_sel` = 2'b10, `rx_irq` pulses only after a transfer that leaves exactly three characters in the queue.
- R7: With `irq_sel` = 2'b11, `rx_irq` pulses only after a transfer that leaves the queue full (four characters).
- R8: `rx_overrun` is set only when a new character strobe arrives while the queue is full and the holding stage already holds a character. That new character is dropped.
- R9: Once set, `rx_overrun` stays 1 until `ovr_clr` is pulsed. While it is 1, every arriving character is dropped and the held character is kept.
- R10: When a read frees a slot while the holding stage is occupied, the held character enters the queue on the following clock edge.
- R11: Synchronous active-low reset empties the queue and the holding stage. It clears `rx_overrun` and `rx_irq` and drives `rx_data`, `rx_perr` and `rx_ferr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chr_stb | input | 1 | A finished character is present this cycle (stop bit detected) |
| chr_data | input | 9 | Received character |
| chr_perr | input | 1 | Parity error of the received character |
| chr_ferr | input | 1 | Framing error of the received character |
| rd_stb | input | 1 | Retire the oldest queued character |
| irq_sel | input | 2 | Interrupt threshold mode |
| ovr_clr | input | 1 | Clear the overrun flag |
| rx_avail | output | 1 | Queue holds at least one character |
| rx_data | output | 9 | Oldest queued character, or last read value when empty |
| rx_perr | output | 1 | Parity error of `rx_data` |
| rx_ferr | output | 1 | Framing error of `rx_data` |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
Some properties are checked on every cycle. The occupancy bound holds at all times. Overrun rises only from the full-queue, held-character and new-strobe combination, and it stays set without a clear. A blocked held character stays unchanged. An empty read leaves the outputs stable. In the two threshold modes, an interrupt pulse always lines up with an occupancy of three or four. Other behaviours can only be shown by the bench's scenarios: the arrival order of five characters across the holding stage and the queue, the exact pulse counts per mode over a fill and a drain, the one-cycle move of a held character after a read, the drop of characters while overrun is set, and the empty-queue value after a drain.

// File: rtl/uart_rxbuf_pkg.sv
// Shared types for the UART receive character buffer.
// Assumes: the mode encoding matches the 2-bit irq_sel port of the top.
package uart_rxbuf_pkg;

    typedef enum logic [1:0] {
        IRQ_EACH_A = 2'b00,
        IRQ_EACH_B = 2'b01,
        IRQ_THREE  = 2'b10,
        IRQ_FULL   = 2'b11
    } irq_mode_e;

    typedef struct packed {
        logic perr;
        logic ferr;
    } rx_err_t;

endpackage

// File: rtl/rx_hold_stage.sv
// Single-character holding stage in front of the receive queue.
// It captures a finished character, offers it to the queue, and tracks the
// sticky overrun condition.
// Assumes: fifo_full is the registered occupancy state of the queue.
module rx_hold_stage
    import uart_rxbuf_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_stb,
    input  logic [DATA_W-1:0] chr_data,
    input  rx_err_t           chr_err,
    input  logic              fifo_full,
    input  logic              ovr_clr,
    output logic              hold_vld,
    output logic [DATA_W-1:0] hold_data,
    output rx_err_t           hold_err,
    output logic              push,
    output logic              overrun
);

    logic accept;
    logic collide;

    // Transfer the held character whenever the queue has room.
    assign push    = hold_vld && !fifo_full;
    // A new character is taken if the stage is free or empties this cycle.
    assign accept  = chr_stb && !overrun && (!hold_vld || push);
    // Full queue plus occupied stage plus new strobe means overrun.
    assign collide = chr_stb && !overrun && hold_vld && !push;

    // Holding register: capture new characters, release on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_data <= '0;
            hold_err  <= '0;
        end else if (accept) begin
            hold_vld  <= 1'b1;
            hold_data <= chr_data;
            hold_err  <= chr_err;
        end else if (push) begin
            hold_vld  <= 1'b0;
        end
    end

    // Sticky overrun flag: set by a collision, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (collide) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end

    p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(chr_stb && hold_vld && fifo_full));

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    p_hold_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && fifo_full) |=> (hold_vld && $stable(hold_data)));

endmodule

// File: rtl/rx_fifo.sv
// Receive queue with a registered "last read" value for empty reads.
// While the queue holds data, the outputs show its oldest entry. When it is
// empty, they show the entry most recently retired.
// Assumes: push is never asserted while full (the holding stage ensures it).
module rx_fifo
    import uart_rxbuf_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  rx_err_t           werr,
    input  logic              rd_stb,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              full,
    output logic              pop,
    output logic              avail,
    output logic [DATA_W-1:0] top_data,
    output rx_err_t           top_err
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] slot_data [DEPTH];
    rx_err_t           slot_err  [DEPTH];
    logic [DATA_W-1:0] last_data;
    rx_err_t           last_err;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CNT_W'(DEPTH));
    assign avail    = (count != '0);
    assign pop      = rd_stb && avail;
    assign top_data = avail ? slot_data[rd_ptr] : last_data;
    assign top_err  = avail ? slot_err[rd_ptr]  : last_err;

    // Storage slots, one writer process per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && wr_ptr == PTR_W'(g)) begin
                slot_data[g] <= wdata;
                slot_err[g]  <= werr;
            end
        end
    end

    // Pointers and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) wr_ptr <= ptr_next(wr_ptr);
            if (pop)           rd_ptr <= ptr_next(rd_ptr);
            count <= count + CNT_W'(push && !full) - CNT_W'(pop);
        end
    end

    // Remember the retired word so an empty read returns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_data <= '0;
            last_err  <= '0;
        end else if (pop) begin
            last_data <= slot_data[rd_ptr];
            last_err  <= slot_err[rd_ptr];
        end
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == CNT_W'(1)) |=> !avail);

    p_push_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !avail) |=> avail);

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !avail && !push) |=> (!avail && $stable(top_data) && $stable(top_err)));

endmodule

// File: rtl/rx_irq_gen.sv
// Receive interrupt pulse generator with selectable occupancy thresholds.
// Assumes: count is the queue occupancy before this cycle's push and pop.
module rx_irq_gen
    import uart_rxbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  irq_mode_e                  mode,
    output logic                       rx_irq
);

    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int OCC_W = CNT_W + 1;

    logic [OCC_W-1:0] occ_after;
    logic             fire;

    // Occupancy that the queue will have after this cycle.
    assign occ_after = OCC_W'(count) + OCC_W'(push) - OCC_W'(pop);

    // Decide whether this transfer meets the selected threshold.
    always_comb begin
        unique case (mode)
            IRQ_THREE: fire = push && (occ_after == OCC_W'(DEPTH-1));
            IRQ_FULL:  fire = push && (occ_after == OCC_W'(DEPTH));
            default:   fire = push;
        endcase
    end

    // Register the pulse so it lines up with the updated occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_irq <= 1'b0;
        else        rx_irq <= fire;
    end

    p_each_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(push) && !$past(mode[1])) |-> rx_irq);

    p_three_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && $past(mode) == IRQ_THREE) |-> (count == CNT_W'(DEPTH-1)));

    p_full_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && $past(mode) == IRQ_FULL) |-> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/uart_rx_buffer.sv
// UART receive character buffer: a holding stage, a queue, and an interrupt
// generator. Characters arrive as one-cycle strobes at stop-bit detection.
// Assumes: rd_stb and ovr_clr are single-cycle pulses from the bus side.
module uart_rx_buffer
    import uart_rxbuf_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_stb,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_perr,
    input  logic              chr_ferr,
    input  logic              rd_stb,
    input  logic [1:0]        irq_sel,
    input  logic              ovr_clr,
    output logic              rx_avail,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_irq,
    output logic              rx_overrun
);

    localparam int CNT_W = $clog2(DEPTH+1);

    rx_err_t           in_err;
    rx_err_t           hold_err;
    rx_err_t           top_err;
    logic              hold_vld;
    logic [DATA_W-1:0] hold_data;
    logic              push;
    logic              pop;
    logic              full;
    logic [CNT_W-1:0]  count;

    assign in_err  = '{perr: chr_perr, ferr: chr_ferr};
    assign rx_perr = top_err.perr;
    assign rx_ferr = top_err.ferr;

    rx_hold_stage #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr_stb   (chr_stb),
        .chr_data  (chr_data),
        .chr_err   (in_err),
        .fifo_full (full),
        .ovr_clr   (ovr_clr),
        .hold_vld  (hold_vld),
        .hold_data (hold_data),
        .hold_err  (hold_err),
        .push      (push),
        .overrun   (rx_overrun)
    );

    rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wdata    (hold_data),
        .werr     (hold_err),
        .rd_stb   (rd_stb),
        .count    (count),
        .full     (full),
        .pop      (pop),
        .avail    (rx_avail),
        .top_data (rx_data),
        .top_err  (top_err)
    );

    rx_irq_gen #(.DEPTH(DEPTH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .count  (count),
        .mode   (irq_mode_e'(irq_sel)),
        .rx_irq (rx_irq)
    );

    p_held_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !full && !chr_stb) |=> (!hold_vld && rx_avail));

endmodule

// File: tb/test_uart_rx_buffer.sv
// Self-checking bench: sweeps every interrupt mode over fill, overrun,
// drain and empty-read sequences, with expected values computed here.
module test_uart_rx_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_stb = 1'b0;
    logic [8:0] chr_data = '0;
    logic       chr_perr = 1'b0;
    logic       chr_ferr = 1'b0;
    logic       rd_stb = 1'b0;
    logic [1:0] irq_sel = 2'b00;
    logic       ovr_clr = 1'b0;
    logic       rx_avail;
    logic [8:0] rx_data;
    logic       rx_perr;
    logic       rx_ferr;
    logic       rx_irq;
    logic       rx_overrun;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_rx_buffer i_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .chr_stb(chr_stb), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr), .rd_stb(rd_stb),
        .irq_sel(irq_sel), .ovr_clr(ovr_clr), .rx_avail(rx_avail),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_irq(rx_irq), .rx_overrun(rx_overrun)
    );

    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    function automatic logic [8:0] pat_d(input int m, input int i);
        return 9'((m * 53 + i * 29 + 5) % 512);
    endfunction
    function automatic logic pat_p(input int m, input int i);
        return ((m + i) % 2) == 1;
    endfunction
    function automatic logic pat_f(input int i);
        return (i % 3) == 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        irq_cnt = 0;
    endtask

    task automatic send(input int m, input int i);
        @(negedge clk);
        chr_stb  = 1'b1;
        chr_data = pat_d(m, i);
        chr_perr = pat_p(m, i);
        chr_ferr = pat_f(i);
        @(negedge clk);
        chr_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd();
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Compares the visible word with the expected (m,i) character.
    task automatic chk_top(input int m, input int i, input string req);
        chk(rx_data == pat_d(m, i), req, int'(rx_data), int'(pat_d(m, i)));
        chk(rx_perr == pat_p(m, i), req, int'(rx_perr), int'(pat_p(m, i)));
        chk(rx_ferr == pat_f(i), req, int'(rx_ferr), int'(pat_f(i)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 4; m++) begin
            int exp_fill;
            int exp_all;
            do_reset();
            // R11 reset state
            chk(rx_avail == 1'b0, "R11", int'(rx_avail), 0);
            chk(rx_overrun == 1'b0, "R11", int'(rx_overrun), 0);
            chk(rx_data == 9'd0, "R11", int'(rx_data), 0);
            irq_sel = 2'(m);
            // Fill: four in the queue, one in the holding stage (R1, R2)
            for (int i = 0; i < 5; i++) begin
                send(m, i);
                chk(rx_avail == 1'b1, "R2", int'(rx_avail), 1);
                chk(rx_overrun == 1'b0, "R1", int'(rx_overrun), 0);
            end
            chk_top(m, 0, "R3");
            exp_fill = (m < 2) ? 4 : 1;
            exp_all  = (m < 2) ? 5 : ((m == 2) ? 1 : 2);
            chk(irq_cnt == exp_fill, (m < 2) ? "R5" : ((m == 2) ? "R6" : "R7"),
                irq_cnt, exp_fill);
            // Sixth character collides (R8), seventh is dropped while set (R9)
            send(m, 5);
            chk(rx_overrun == 1'b1, "R8", int'(rx_overrun), 1);
            send(m, 6);
            chk(rx_overrun == 1'b1, "R9", int'(rx_overrun), 1);
            // Drain in order; the held character follows the queue (R3, R10)
            for (int k = 0; k < 5; k++) begin
                chk(rx_avail == 1'b1, "R2", int'(rx_avail), 1);
                chk_top(m, k, "R3");
                rd();
            end
            chk(rx_avail == 1'b0, "R2", int'(rx_avail), 0);
            chk(irq_cnt == exp_all, (m < 2) ? "R5" : ((m == 2) ? "R6" : "R10"),
                irq_cnt, exp_all);
            chk(rx_overrun == 1'b1, "R9", int'(rx_overrun), 1);
            // Empty read keeps the last retired word (R4)
            rd();
            chk(rx_avail == 1'b0, "R4", int'(rx_avail), 0);
            chk_top(m, 4, "R4");
            // Character arriving while overrun is set is dropped (R9)
            send(m, 8);
            chk(rx_avail == 1'b0, "R9", int'(rx_avail), 0);
            // Software clear, then normal reception again (R9)
            @(negedge clk);
            ovr_clr = 1'b1;
            @(negedge clk);
            ovr_clr = 1'b0;
            chk(rx_overrun == 1'b0, "R9", int'(rx_overrun), 0);
            send(m, 7);
            chk(rx_avail == 1'b1, "R2", int'(rx_avail), 1);
            chk_top(m, 7, "R3");
        end

        // R10 timing: after a read, the held character enters one edge later
        do_reset();
        irq_sel = 2'b11;
        for (int i = 0; i < 5; i++) send(9, i);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(rx_irq == 1'b0, "R10", int'(rx_irq), 0);
        @(negedge clk);
        chk(rx_irq == 1'b1, "R10", int'(rx_irq), 1);
        @(negedge clk);
        chk(rx_irq == 1'b0, "R7", int'(rx_irq), 0);

        // R6: three reached twice across an interleaved read
        do_reset();
        irq_sel = 2'b10;
        for (int i = 0; i < 3; i++) send(3, i);
        chk(irq_cnt == 1, "R6", irq_cnt, 1);
        rd();
        send(3, 3);
        chk(irq_cnt == 2, "R6", irq_cnt, 2);
        send(3, 4);
        chk(irq_cnt == 2, "R6", irq_cnt, 2);
        chk_top(3, 1, "R3");

        // R2 latency: strobe at edge k, data visible after edge k+1
        do_reset();
        irq_sel = 2'b00;
        @(negedge clk);
        chr_stb  = 1'b1;
        chr_data = pat_d(4, 1);
        chr_perr = pat_p(4, 1);
        chr_ferr = pat_f(1);
        @(negedge clk);
        chr_stb = 1'b0;
        chk(rx_avail == 1'b0, "R2", int'(rx_avail), 0);
        @(negedge clk);
        chk(rx_avail == 1'b1, "R2", int'(rx_avail), 1);
        chk(rx_irq == 1'b1, "R5", int'(rx_irq), 1);

        // R11: reset with content present empties everything
        send(4, 2);
        do_reset();
        chk(rx_avail == 1'b0, "R11", int'(rx_avail), 0);
        chk(rx_data == 9'd0, "R11", int'(rx_data), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule